// File: doc/BRIEF.md
# Receive Size-Error Statistics Counters

This block keeps two receive statistics for one Ethernet port: the number of runt frames that also failed their CRC check, and the number of frames longer than the permitted maximum. The receive MAC gives it one summary event per completed frame. Each event carries the frame length in bytes, counted from the first destination-address byte through the last CRC byte. It also carries a flag for a good CRC and a flag for an address-filter match. Two configuration levels are sampled with each event: receive enable, and a long-packet mode that raises the oversize threshold.

Software reads either counter through a small register read port. Data comes back one cycle after the read strobe. The read clears the counter that was read, so each read returns the events seen since the previous read. The counters saturate rather than wrap. An event that arrives in the same cycle as the clearing read is kept.

Top module: `rx_size_err_stats`

## Requirements
- R1: After reset both counters read as zero, `rd_data` is zero and `rd_valid` is low.
- R2: An event (`eof_valid` high) changes a counter only when `eof_addr_match` and `rx_en` are both high in that cycle. Otherwise neither counter changes.
- R3: The fragment counter (offset 0) increments by one for a qualifying frame whose length is below 64 bytes and whose `eof_crc_ok` is low. A 64-byte frame does not count. A short frame with a good CRC does not count.
- R4: With `long_pkt_en` low, the oversize counter (offset 4) increments for a qualifying frame longer than 1522 bytes, whatever its CRC flag. A 1522-byte frame does not count.
- R5: With `long_pkt_en` high, the oversize threshold is 16384 bytes. A 16384-byte frame does not count, a 16385-byte frame does, and so does a 20000-byte frame (the length input is at least 15 bits wide).
- R6: A read strobe with `rd_addr` 0 returns the fragment count and with `rd_addr` 4 returns the oversize count. Any other address returns zero. `rd_data` and a one-cycle `rd_valid` pulse appear in the cycle after the strobe.
- R7: A read returns the counter value from before the strobe edge and clears that counter. The other counter is not cleared, and a read of an unmapped address clears nothing.
- R8: If a read clears a counter in the same cycle an increment reaches it, the read returns the old value and the counter becomes 1.
- R9: A counter at all-ones stays at all-ones on further increments. The counters are 32 bits at the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable level |
| long_pkt_en | input | 1 | Long-packet mode: oversize threshold 16384 instead of 1522 |
| eof_valid | input | 1 | End-of-frame summary event strobe |
| eof_len | input | LEN_W (16) | Frame length in bytes, destination address through CRC |
| eof_crc_ok | input | 1 | Frame CRC was good |
| eof_addr_match | input | 1 | Frame passed address filtering |
| rd_stb | input | 1 | Register read strobe, clears the selected counter |
| rd_addr | input | ADDR_W (3) | Byte offset of the register read |
| rd_data | output | DATA_W (32) | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_stb |

## Verification
Frames are sent at lengths on both sides of each threshold: 63/64, 1522/1523, 16384/16385 and 20000. This separates strict from inclusive comparisons and shows whether the mode bit selects the right limit. Short frames are sent with good and bad CRC, and oversize frames with a bad CRC, to show that only the fragment class depends on the CRC. Frames with the address flag or receive enable low show that the gate applies to both counters. Reads of each offset and of an unmapped offset are checked for clearing the right counter only. A read in the same cycle as an event, and a narrow second instance driven past its maximum, cover the collision and saturation rules.

// File: rtl/rx_size_stats_pkg.sv
package rx_size_stats_pkg;
  localparam int unsigned MIN_FRAME_BYTES = 64;
  localparam int unsigned MAX_STD_BYTES   = 1522;
  localparam int unsigned MAX_LONG_BYTES  = 16384;
  localparam int unsigned NUM_STATS       = 2;
  localparam int unsigned REG_STRIDE      = 4;

  typedef enum int unsigned {
    STAT_FRAG = 0,
    STAT_OVS  = 1
  } stat_idx_e;
endpackage

// File: rtl/rx_size_classify.sv
module rx_size_classify
  import rx_size_stats_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             ev_valid_i,
  input  logic [LEN_W-1:0] ev_len_i,
  input  logic             ev_crc_ok_i,
  input  logic             ev_addr_hit_i,
  input  logic             rx_en_i,
  input  logic             long_en_i,
  output logic             hit_frag_o,
  output logic             hit_ovs_o
);
  localparam logic [LEN_W-1:0] MinLen  = LEN_W'(MIN_FRAME_BYTES);
  localparam logic [LEN_W-1:0] StdMax  = LEN_W'(MAX_STD_BYTES);
  localparam logic [LEN_W-1:0] LongMax = LEN_W'(MAX_LONG_BYTES);

  logic             qualified;
  logic [LEN_W-1:0] limit;

  always_comb begin
    qualified  = ev_valid_i && ev_addr_hit_i && rx_en_i;
    limit      = long_en_i ? LongMax : StdMax;
    hit_frag_o = qualified && !ev_crc_ok_i && (ev_len_i < MinLen);
    hit_ovs_o  = qualified && (ev_len_i > limit);
  end
endmodule

// File: rtl/rx_stat_counter.sv
module rx_stat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc_i || clr_i;
    if (clr_i)                 cnt_d = inc_i ? CNT_W'(1) : '0;
    else if (cnt_q == CntMax)  cnt_d = cnt_q;
    else                       cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R9: saturation
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CntMax && inc_i && !clr_i) |=> (cnt_q == CntMax));
  // R7: clear without a coinciding event leaves zero
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !inc_i) |=> (cnt_q == '0));
  // R8: clear colliding with an increment leaves one
  a_r8_clear_inc_one: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && inc_i) |=> (cnt_q == CNT_W'(1)));
  // R2: no event and no clear means the value holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_stat_rdport.sv
module rx_stat_rdport
  import rx_size_stats_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned NUM_CNT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_stb_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] counts_i,
  output logic [NUM_CNT-1:0]            clr_o,
  output logic [DATA_W-1:0]             rd_data_o,
  output logic                          rd_valid_o
);
  logic [NUM_CNT-1:0] hit;
  logic [CNT_W-1:0]   sel_cnt;
  logic [DATA_W-1:0]  data_d, data_q;
  logic               valid_q;

  always_comb begin
    hit     = '0;
    sel_cnt = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rd_addr_i == ADDR_W'(i * REG_STRIDE)) begin
        hit[i]  = 1'b1;
        sel_cnt = counts_i[i];
      end
    end
    clr_o  = hit & {NUM_CNT{rd_stb_i}};
    data_d = DATA_W'(sel_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_stb_i;
      if (rd_stb_i) data_q <= data_d;
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;

  // R6: valid follows the strobe by exactly one cycle
  a_r6_valid_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i |=> rd_valid_o);
  a_r6_no_valid_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb_i |=> !rd_valid_o);
  // R7: at most one counter is cleared by a read
  a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_o));
endmodule

// File: rtl/rx_size_err_stats.sv
module rx_size_err_stats
  import rx_size_stats_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              long_pkt_en,
  input  logic              eof_valid,
  input  logic [LEN_W-1:0]  eof_len,
  input  logic              eof_crc_ok,
  input  logic              eof_addr_match,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int unsigned NumCnt = NUM_STATS;

  logic                         hit_frag, hit_ovs;
  logic [NumCnt-1:0]            inc_vec, clr_vec;
  logic [NumCnt-1:0][CNT_W-1:0] cnt_vec;

  rx_size_classify #(.LEN_W(LEN_W)) u_classify (
    .ev_valid_i    (eof_valid),
    .ev_len_i      (eof_len),
    .ev_crc_ok_i   (eof_crc_ok),
    .ev_addr_hit_i (eof_addr_match),
    .rx_en_i       (rx_en),
    .long_en_i     (long_pkt_en),
    .hit_frag_o    (hit_frag),
    .hit_ovs_o     (hit_ovs)
  );

  always_comb begin
    inc_vec            = '0;
    inc_vec[STAT_FRAG] = hit_frag;
    inc_vec[STAT_OVS]  = hit_ovs;
  end

  for (genvar g = 0; g < NumCnt; g++) begin : g_cnt
    rx_stat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (inc_vec[g]),
      .clr_i   (clr_vec[g]),
      .count_o (cnt_vec[g])
    );
  end

  rx_stat_rdport #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CNT(NumCnt)
  ) u_rdport (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb_i   (rd_stb),
    .rd_addr_i  (rd_addr),
    .counts_i   (cnt_vec),
    .clr_o      (clr_vec),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid)
  );

  // R2: with receive disabled and no read, no counter moves
  a_r2_disabled_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rd_stb) |=> $stable(cnt_vec));
  // R3: a frame with a good CRC never advances the fragment count without a read
  a_r3_good_crc_no_frag: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_crc_ok && !rd_stb) |=> $stable(cnt_vec[STAT_FRAG]));
endmodule

// File: tb/tb_rx_size_err_stats.sv
module tb_rx_size_err_stats;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0, long_pkt_en = 1'b0;
  logic        eof_valid = 1'b0, eof_crc_ok = 1'b0, eof_addr_match = 1'b0;
  logic [15:0] eof_len = '0;
  logic        rd_stb = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data, rd_data_s;
  logic        rd_valid, rd_valid_s;

  int tests = 0, fails = 0;
  logic [31:0] rv, rvs;

  always #(CLK_P/2) clk = ~clk;

  rx_size_err_stats dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .long_pkt_en(long_pkt_en),
    .eof_valid(eof_valid), .eof_len(eof_len), .eof_crc_ok(eof_crc_ok),
    .eof_addr_match(eof_addr_match), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid));

  rx_size_err_stats #(.CNT_W(4)) dut_sat (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .long_pkt_en(long_pkt_en),
    .eof_valid(eof_valid), .eof_len(eof_len), .eof_crc_ok(eof_crc_ok),
    .eof_addr_match(eof_addr_match), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data_s), .rd_valid(rd_valid_s));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int len, input logic crc_ok, input logic am);
    @(negedge clk);
    eof_valid = 1'b1; eof_len = 16'(len); eof_crc_ok = crc_ok; eof_addr_match = am;
    @(negedge clk);
    eof_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] addr);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = addr;
    @(negedge clk);
    rd_stb = 1'b0;
    rv = rd_data; rvs = rd_data_s;
    check("R6 rd_valid", {31'b0, rd_valid}, 32'd1);
  endtask

  task automatic clear_all();
    rd(3'd0); rd(3'd4);
  endtask

  task automatic t_reset();
    check("R1 rd_data", rd_data, 32'd0);
    check("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
    rd(3'd0); check("R1 frag", rv, 0);
    rd(3'd4); check("R1 ovs", rv, 0);
  endtask

  task automatic t_gating();
    rx_en = 1'b1; long_pkt_en = 1'b0;
    send(40, 1'b0, 1'b0);    // no address match
    send(2000, 1'b1, 1'b0);
    rx_en = 1'b0;
    send(40, 1'b0, 1'b1);    // receive disabled
    send(2000, 1'b1, 1'b1);
    rx_en = 1'b1;
    rd(3'd0); check("R2 frag gated", rv, 0);
    rd(3'd4); check("R2 ovs gated", rv, 0);
  endtask

  task automatic t_fragment();
    send(63, 1'b0, 1'b1);   // counts
    send(10, 1'b0, 1'b1);   // counts
    send(64, 1'b0, 1'b1);   // boundary, not a fragment
    send(40, 1'b1, 1'b1);   // good CRC
    rd(3'd0); check("R3 fragment count", rv, 2);
    rd(3'd4); check("R3 no ovs from short", rv, 0);
  endtask

  task automatic t_ovs_std();
    long_pkt_en = 1'b0;
    send(1522, 1'b1, 1'b1);
    send(1523, 1'b1, 1'b1);
    send(3000, 1'b0, 1'b1);
    rd(3'd4); check("R4 oversize std", rv, 2);
    rd(3'd0); check("R4 no frag from long", rv, 0);
  endtask

  task automatic t_ovs_long();
    long_pkt_en = 1'b1;
    send(1523, 1'b1, 1'b1);
    send(16384, 1'b1, 1'b1);
    send(16385, 1'b1, 1'b1);
    send(20000, 1'b0, 1'b1);
    rd(3'd4); check("R5 oversize long", rv, 2);
    long_pkt_en = 1'b0;
  endtask

  task automatic t_addr_clear();
    send(30, 1'b0, 1'b1);
    send(2000, 1'b1, 1'b1);
    send(2001, 1'b1, 1'b1);
    rd(3'd2); check("R6 unmapped reads zero", rv, 0);
    rd(3'd6); check("R6 unmapped reads zero", rv, 0);
    rd(3'd4); check("R6 ovs offset", rv, 2);
    rd(3'd4); check("R7 ovs cleared", rv, 0);
    rd(3'd0); check("R7 frag kept by other reads", rv, 1);
    rd(3'd0); check("R7 frag cleared", rv, 0);
  endtask

  task automatic t_collide();
    send(20, 1'b0, 1'b1);
    send(21, 1'b0, 1'b1);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = 3'd0;
    eof_valid = 1'b1; eof_len = 16'd22; eof_crc_ok = 1'b0; eof_addr_match = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; eof_valid = 1'b0;
    check("R8 old value on collide", rd_data, 2);
    rd(3'd0); check("R8 counter became one", rv, 1);
  endtask

  task automatic t_saturate();
    clear_all();
    for (int i = 0; i < 17; i++) send(12, 1'b0, 1'b1);
    rd(3'd0);
    check("R9 wide counter", rv, 17);
    check("R9 narrow counter saturates", rvs, 15);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_gating();
    t_fragment();
    t_ovs_std();
    t_ovs_long();
    t_addr_clear();
    t_collide();
    t_saturate();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule